// File: doc/BRIEF.md
# Serial Flash Power-Down Wake Detector

This block is the command front end of a serial flash slave for the time the device spends in deep power-down. It watches the serial clock, the active-low chip select and the serial data input, counts the bits of each framed transaction and decides, at the moment chip select is released, whether that frame was a legal wake-up request. All three serial pins are brought into the system clock domain through a short synchronizer before any decision is made.

A legal request is a frame whose first byte, sent most significant bit first, equals the wake opcode, and whose total length is a whole number of bytes. Any bytes after the first are ignored. A legal request starts a wake-up timer of a fixed number of system clock cycles, and the block reports standby when the timer runs out. A power-down entry strobe moves the block from standby into power-down. Every other frame, and every frame seen outside power-down, leaves the state unchanged.

Top module: `sflash_wake_detect`

## Requirements
- R1: While reset is high and in the first cycle after it, `ready` is 1 and `pd_flag` is 0 (standby).
- R2: A `pd_enter` pulse sampled in standby sets `pd_flag` to 1 and `ready` to 0 at the next clock edge; `pd_enter` has no effect while powered down or while waking.
- R3: In power-down, a frame whose first eight bits, taken MSB first from SI on SCK rising edges while `cs_n` is low, equal 0xAB (1010_1011) and whose length is exactly eight bits clears `pd_flag` after `cs_n` rises.
- R4: In power-down, a whole-byte frame whose first byte is anything other than 0xAB leaves `pd_flag` at 1 and `ready` at 0.
- R5: Bits after the first byte do not change the decision: a 16- or 24-bit frame starting with 0xAB wakes the block.
- R6: A frame of fewer than eight bits leaves the block in power-down, even if those bits are a prefix of 0xAB.
- R7: A frame whose bit count is not a multiple of eight leaves the block in power-down, whatever its first byte.
- R8: The decision is taken on the release of `cs_n`, not on the eighth bit: with `cs_n` held low after a full 0xAB byte, `pd_flag` stays 1.
- R9: `ready` rises exactly WAKE_CYCLES clock edges after `pd_flag` falls, and both are 0 during that interval.
- R10: `pd_flag` and `ready` are never 1 at the same time.
- R11: An SCK rising edge that reaches the synchronized domain in the same cycle as the `cs_n` release is counted as part of the frame.
- R12: Frames sent while in standby leave `ready` at 1 and `pd_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, puts the block in standby |
| sck | input | 1 | Serial clock from the host, sampled asynchronously |
| cs_n | input | 1 | Active-low chip select from the host |
| si | input | 1 | Serial data input, MSB first |
| pd_enter | input | 1 | One-cycle strobe requesting deep power-down |
| pd_flag | output | 1 | 1 while in deep power-down |
| ready | output | 1 | 1 when in standby and able to take normal commands |

## Verification
The delicate coincidence is the final SCK rising edge and the chip-select release landing in the same synchronized cycle, where the decision must include the bit still being shifted. The bench provokes it by switching `sck` and `cs_n` on the same instant for the last bit of a frame, once with a full 0xAB byte, which must wake, and once with a nine-bit frame, which must not. The second coincidence, a `pd_enter` strobe arriving while the wake timer runs, is driven mid-wake and judged by `ready` still rising on schedule with `pd_flag` held at 0.

// File: rtl/pdwake_pkg.sv
package pdwake_pkg;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_DOWN    = 2'd1,
    ST_WAKING  = 2'd2
  } pw_state_e;

endpackage

// File: rtl/pdwake_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins. Gives the
// synchronized value and the one before it, for edge detection.
module pdwake_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dprev
);

  logic [STAGES:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {(STAGES+1){RST_VAL}};
    end else begin
      pipe <= {pipe[STAGES-1:0], din};
    end
  end

  assign dout  = pipe[STAGES-1];
  assign dprev = pipe[STAGES];

endmodule

// File: rtl/pdwake_shifter.sv
// Collects the first opcode of a frame and tracks the bit phase within a
// byte. frame_ok reflects the state after the current strobe is applied,
// so a bit arriving with the chip-select release is included.
module pdwake_shifter #(
  parameter int                  OPC_BITS = 8,
  parameter logic [OPC_BITS-1:0] OPC      = 8'hAB
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_stb,
  input  logic bit_val,
  output logic frame_ok
);

  localparam int PW = (OPC_BITS > 2) ? $clog2(OPC_BITS) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(OPC_BITS - 1);

  logic [PW-1:0]       phase_q, phase_d;
  logic                full_q, full_d;
  logic [OPC_BITS-1:0] opc_q, opc_d;

  always_comb begin
    phase_d = phase_q;
    full_d  = full_q;
    opc_d   = opc_q;
    if (bit_stb) begin
      phase_d = (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
      if (!full_q) begin
        opc_d = {opc_q[OPC_BITS-2:0], bit_val};
        if (phase_q == LAST_PH) full_d = 1'b1;
      end
    end
  end

  assign frame_ok = full_d && (phase_d == '0) && (opc_d == OPC);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q <= '0;
      full_q  <= 1'b0;
      opc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      full_q  <= full_d;
      opc_q   <= opc_d;
    end
  end

endmodule

// File: rtl/pdwake_timer.sv
// Wake-up delay counter: after load, done is high in the CYCLES-th enabled
// cycle.
module pdwake_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  output logic done
);

  localparam int TW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= TW'(CYCLES - 1);
    end else if (en && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = en && (cnt_q == '0);

endmodule

// File: rtl/sflash_wake_detect.sv
module sflash_wake_detect
  import pdwake_pkg::*;
#(
  parameter int                  OPC_BITS    = 8,
  parameter logic [OPC_BITS-1:0] WAKE_OPC    = 8'hAB,
  parameter int                  WAKE_CYCLES = 20,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic pd_enter,
  output logic pd_flag,
  output logic ready
);

  // pin bundle order: {sck, cs_n, si}; idle is sck low, cs_n high
  localparam logic [2:0] PIN_IDLE = 3'b010;

  logic [2:0] pin_now, pin_prev;
  logic       sck_rise, cs_rise, cs_was_low;
  logic       bit_stb, shift_clr, frame_ok;
  logic       wake_go, tmr_done;
  logic       unused_si_prev;
  pw_state_e  state_q;

  pdwake_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({sck, cs_n, si}),
    .dout (pin_now),
    .dprev(pin_prev)
  );

  assign unused_si_prev = pin_prev[0];
  assign cs_was_low     = !pin_prev[1];
  assign sck_rise       = pin_now[2] && !pin_prev[2];
  assign cs_rise        = pin_now[1] && !pin_prev[1];
  assign bit_stb        = sck_rise && cs_was_low && (state_q == ST_DOWN);
  assign shift_clr      = pin_now[1] || (state_q != ST_DOWN);

  pdwake_shifter #(
    .OPC_BITS(OPC_BITS),
    .OPC     (WAKE_OPC)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .clr     (shift_clr),
    .bit_stb (bit_stb),
    .bit_val (pin_now[0]),
    .frame_ok(frame_ok)
  );

  assign wake_go = (state_q == ST_DOWN) && cs_rise && frame_ok;

  pdwake_timer #(
    .CYCLES(WAKE_CYCLES)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .load(wake_go),
    .en  (state_q == ST_WAKING),
    .done(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_STANDBY;
      pd_flag <= 1'b0;
      ready   <= 1'b1;
    end else begin
      case (state_q)
        ST_STANDBY: if (pd_enter) begin
          state_q <= ST_DOWN;
          pd_flag <= 1'b1;
          ready   <= 1'b0;
        end
        ST_DOWN: if (wake_go) begin
          state_q <= ST_WAKING;
          pd_flag <= 1'b0;
        end
        ST_WAKING: if (tmr_done) begin
          state_q <= ST_STANDBY;
          ready   <= 1'b1;
        end
        default: begin
          state_q <= ST_STANDBY;
          pd_flag <= 1'b0;
          ready   <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/pdwake_chk.sv
module pdwake_chk #(
  parameter int WAKE_CYCLES = 20
) (
  input logic clk,
  input logic rst,
  input logic pd_enter,
  input logic pd_flag,
  input logic ready,
  input logic cs_rise,
  input logic frame_ok
);

  localparam int GW = $clog2(WAKE_CYCLES + 2);

  logic [GW-1:0] gap_q;

  // cycles spent with both flags low since power-down ended
  always_ff @(posedge clk) begin
    if (rst || pd_flag || ready) gap_q <= '0;
    else if (gap_q != GW'(WAKE_CYCLES + 1)) gap_q <= gap_q + 1'b1;
  end

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(pd_flag && ready));

  assert_enter_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && pd_enter) |=> (pd_flag && !ready));

  assert_enter_src_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_flag) |-> $past(pd_enter && ready));

  assert_wake_src_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_flag) |-> ($past(cs_rise && frame_ok) && !ready));

  assert_hold_down_R8: assert property (@(posedge clk) disable iff (rst)
    (pd_flag && !cs_rise) |=> pd_flag);

  assert_wake_time_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (gap_q == GW'(WAKE_CYCLES)));

endmodule

bind sflash_wake_detect pdwake_chk #(
  .WAKE_CYCLES(WAKE_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pd_enter(pd_enter),
  .pd_flag (pd_flag),
  .ready   (ready),
  .cs_rise (cs_rise),
  .frame_ok(frame_ok)
);

// File: tb/sflash_wake_detect_tb_top.sv
`timescale 1ns/1ps
module sflash_wake_detect_tb_top;

  localparam int WAKE = 20;
  localparam int SEED = 32'h5EED_0A1B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic pd_enter = 1'b0;
  logic pd_flag, ready;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sflash_wake_detect #(.WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
    .pd_enter(pd_enter), .pd_flag(pd_flag), .ready(ready)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      summary();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_wake(logic [31:0] bits, int n);
    logic [7:0] first;
    if (n < 8) return 1'b0;
    first = bits[n-1 -: 8];
    return (n % 8 == 0) && (first == 8'hAB);
  endfunction

  // bits are sent from bits[n-1] down to bits[0]
  task automatic send_frame(logic [31:0] bits, int n, bit collide, bit hold);
    cs_n = 1'b0;
    tick(3);
    for (int i = 0; i < n; i++) begin
      si = bits[n-1-i];
      tick(2);
      if (collide && i == n-1) begin
        sck = 1'b1;
        cs_n = 1'b1;
        tick(3);
        sck = 1'b0;
      end else begin
        sck = 1'b1;
        tick(3);
        sck = 1'b0;
        tick(2);
      end
    end
    if (!collide && !hold) cs_n = 1'b1;
    tick(1);
  endtask

  task automatic go_down(string req);
    pd_enter = 1'b1;
    tick(1);
    pd_enter = 1'b0;
    check(pd_flag == 1'b1 && ready == 1'b0, req, "pd_enter from standby",
          {pd_flag, ready}, 2);
  endtask

  task automatic wait_ready(string req);
    int t = 0;
    while (!ready && t < WAKE + 10) begin
      tick(1);
      t++;
    end
    check(ready == 1'b1 && pd_flag == 1'b0, req, "standby after wake",
          {pd_flag, ready}, 1);
  endtask

  // frame in power-down, judged against the expectation computed here
  task automatic judge_frame(logic [31:0] bits, int n, bit collide, string req);
    bit w;
    w = exp_wake(bits, n);
    send_frame(bits, n, collide, 1'b0);
    tick(6);
    check(pd_flag == !w && ready == 1'b0, req, "decision after release",
          {pd_flag, ready}, {!w, 1'b0});
    if (w) begin
      wait_ready(req);
      go_down(req);
    end
  endtask

  initial begin
    void'($urandom(SEED));
    tick(4);
    check(ready == 1'b1 && pd_flag == 1'b0, "R1", "during reset", {pd_flag, ready}, 1);
    rst = 1'b0;
    tick(1);
    check(ready == 1'b1 && pd_flag == 1'b0, "R1", "after reset", {pd_flag, ready}, 1);

    // R12: frame in standby has no effect
    send_frame(32'hAB, 8, 1'b0, 1'b0);
    tick(30);
    check(ready == 1'b1 && pd_flag == 1'b0, "R12", "0xAB in standby", {pd_flag, ready}, 1);

    go_down("R2");
    pd_enter = 1'b1;
    tick(1);
    pd_enter = 1'b0;
    tick(2);
    check(pd_flag == 1'b1 && ready == 1'b0, "R2", "pd_enter while down", {pd_flag, ready}, 2);

    judge_frame(32'hAA, 8, 1'b0, "R4");
    judge_frame(32'h5, 3, 1'b0, "R6");
    judge_frame(32'h55, 7, 1'b0, "R6");
    judge_frame(32'h157, 9, 1'b0, "R7");
    judge_frame(32'hAB3C, 16, 1'b0, "R5");
    judge_frame(32'hAB0FF0, 24, 1'b0, "R5");
    judge_frame(32'hD5, 8, 1'b0, "R4");

    // R8: held chip select after full opcode does not wake
    send_frame(32'hAB, 8, 1'b0, 1'b1);
    tick(40);
    check(pd_flag == 1'b1 && ready == 1'b0, "R8", "cs_n still low", {pd_flag, ready}, 2);
    cs_n = 1'b1;
    tick(6);
    check(pd_flag == 1'b0, "R8", "wake after release", pd_flag, 0);
    wait_ready("R8");
    go_down("R8");

    // R11: last SCK edge together with CS release
    judge_frame(32'hAB, 8, 1'b1, "R11");
    judge_frame(32'h157, 9, 1'b1, "R11");

    // R9 / R10: exact wake interval
    begin
      int tf = -1;
      int tr = -1;
      bit both = 1'b0;
      send_frame(32'hAB, 8, 1'b0, 1'b0);
      for (int t = 0; t < 80; t++) begin
        tick(1);
        if (pd_flag && ready) both = 1'b1;
        if (tf < 0 && !pd_flag) tf = t;
        if (tr < 0 && ready) tr = t;
      end
      check(tf >= 0 && tr - tf == WAKE, "R9", "wake interval", tr - tf, WAKE);
      check(!both, "R10", "flags overlap", both, 0);
      go_down("R9");
    end

    // R3 plus R2: pd_enter during wake is ignored
    send_frame(32'hAB, 8, 1'b0, 1'b0);
    tick(6);
    check(pd_flag == 1'b0 && ready == 1'b0, "R3", "waking after 0xAB", {pd_flag, ready}, 0);
    pd_enter = 1'b1;
    tick(1);
    pd_enter = 1'b0;
    wait_ready("R2");
    go_down("R2");

    // random frames
    for (int k = 0; k < 40; k++) begin
      int n;
      logic [31:0] bits;
      n = 1 + int'($urandom % 24);
      bits = $urandom;
      if (n >= 8 && ($urandom % 2) == 0) bits[n-1 -: 8] = 8'hAB;
      judge_frame(bits, n, ($urandom % 5) == 0, "R3");
    end

    summary();
  end

endmodule